// File: doc/BRIEF.md
# Phase-Accumulating Sine Synthesizer

This block is the digital heart of a direct digital synthesis source. A wide phase accumulator advances by a programmable tuning word on every clock, so the output frequency is the tuning word times the clock rate divided by 2^32. A coarse phase offset, in steps of one thirty-second of a cycle, is added to the upper accumulator bits. The sum addresses a quarter-wave sine table, and the result is a 10-bit offset-binary sample ready for an external converter. The accumulator MSB is also brought out as a square-wave reference at the same frequency.

The tuning word and offset are staged on input ports and copied into an active register only when an update strobe is high, so a controller can prepare new values over several cycles without disturbing the waveform. A power-down input freezes the accumulator and parks the sample at mid-scale.

Top module: `dds_nco`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator, the active tuning word and the active offset are cleared to zero, `sample` becomes 512 and `square` becomes 0.
- R2: At every edge with `pwr_dn` low, the accumulator adds the active tuning word modulo 2^32; `square` is accumulator bit 31, so a tuning word of 2^28 gives a square wave that toggles every 8 clocks.
- R3: `ftw_stage` and `ofs_stage` are copied into the active tuning word and active offset only at an edge where `upd` is high; changing them while `upd` is low leaves `sample` and `square` unchanged.
- R4: The table phase is the 12-bit value (accumulator bits 31:20 + active offset × 128) modulo 4096, so an offset of 8 advances the waveform by a quarter cycle.
- R5: For phase p with quadrant q = p[11:10] and index k = p[9:0], let A(m) = round(511 × sin(2π(m+0.5)/4096)); the sample is 512+A(k) for q=0, 512+A(1023−k) for q=1, 511−A(k) for q=2 and 511−A(1023−k) for q=3 (so offsets 8, 16 and 24 at zero accumulator give 1023, 511 and 0).
- R6: The sample visible after edge n+3 is formed from the accumulator and active offset held after edge n; a new offset loaded at edge e first appears in `sample` after edge e+3.
- R7: At every edge with `pwr_dn` high, the accumulator holds its value and `sample` is set to 512; when `pwr_dn` falls, synthesis resumes from the held phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ftw_stage | input | 32 | Staged frequency tuning word |
| ofs_stage | input | 5 | Staged phase offset in 1/32-cycle steps |
| upd | input | 1 | Copies staged values into the active register |
| pwr_dn | input | 1 | Freezes the accumulator, parks the sample at mid-scale |
| sample | output | 10 | Offset-binary sine sample |
| square | output | 1 | Accumulator MSB, square-wave reference |

## Verification
The checker watches on every cycle that the accumulator steps by exactly the active tuning word, that the active register changes only under the update strobe, and that power-down both freezes the phase and parks the output at mid-scale. The shape of the waveform, the quadrant mirroring, the quarter-cycle offsets, the three-cycle latency and the square-wave period are only shown by the bench's scenarios, which compare every sample against a reference model built from the sine formula.

// File: rtl/dds_nco_pkg.sv
package dds_nco_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // Rounded amplitude of entry m of a quarter-wave table with 2**aw
  // entries and a peak of (2**dw - 1). Sampling at m + 0.5 makes the
  // table symmetric under index inversion.
  function automatic int unsigned quarter_amp(input int m, input int aw, input int dw);
    real full_cycle;
    real peak;
    real ang;
    full_cycle = 4.0 * (2.0 ** aw);
    peak       = (2.0 ** dw) - 1.0;
    ang        = TWO_PI * (real'(m) + 0.5) / full_cycle;
    return int'($rtoi(peak * $sin(ang) + 0.5));
  endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 32,
  parameter int OFS_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] ftw_stage,
  input  logic [OFS_W-1:0] ofs_stage,
  input  logic             upd,
  input  logic             pwr_dn,
  output logic [ACC_W-1:0] acc_q,
  output logic [ACC_W-1:0] ftw_act,
  output logic [OFS_W-1:0] ofs_act
);

  // Active (second) buffer of the tuning word and offset
  always_ff @(posedge clk) begin
    if (rst) begin
      ftw_act <= '0;
      ofs_act <= '0;
    end else if (upd) begin
      ftw_act <= ftw_stage;
      ofs_act <= ofs_stage;
    end
  end

  // Phase accumulator, frozen while powered down
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (!pwr_dn) begin
      acc_q <= acc_q + ftw_act;
    end
  end

endmodule

// File: rtl/dds_phase_map.sv
module dds_phase_map #(
  parameter int OFS_W  = 5,
  parameter int TAB_AW = 10,
  localparam int PH_W  = TAB_AW + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PH_W-1:0]   acc_top,
  input  logic [OFS_W-1:0]  ofs_act,
  output logic [TAB_AW-1:0] tab_addr,
  output logic              neg_half
);

  logic [PH_W-1:0] ofs_ext;
  logic [PH_W-1:0] ph_q;

  // Offset aligned to the top of the table phase
  generate
    if (OFS_W < PH_W) begin : g_ofs_pad
      assign ofs_ext = {ofs_act, {(PH_W - OFS_W){1'b0}}};
    end else begin : g_ofs_trim
      assign ofs_ext = ofs_act[OFS_W-1 -: PH_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= '0;
    end else begin
      ph_q <= acc_top + ofs_ext;
    end
  end

  // Odd quadrants read the table backwards
  assign tab_addr = ph_q[TAB_AW] ? ~ph_q[TAB_AW-1:0] : ph_q[TAB_AW-1:0];
  assign neg_half = ph_q[PH_W-1];

endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
  parameter int AW = 10,
  parameter int DW = 9,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data_q
);
  import dds_nco_pkg::*;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DW'(quarter_amp(i, AW, DW));
    end
  end

  // Synchronous read with resettable output register
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else begin
      data_q <= mem[addr];
    end
  end

endmodule

// File: rtl/dds_nco.sv
module dds_nco #(
  parameter int ACC_W  = 32,
  parameter int OFS_W  = 5,
  parameter int TAB_AW = 10,
  parameter int OUT_W  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] ftw_stage,
  input  logic [OFS_W-1:0] ofs_stage,
  input  logic             upd,
  input  logic             pwr_dn,
  output logic [OUT_W-1:0] sample,
  output logic             square
);

  localparam int PH_W = TAB_AW + 2;
  localparam int AMP_W = OUT_W - 1;
  localparam logic [OUT_W-1:0] MID = OUT_W'(1) << (OUT_W - 1);

  logic [ACC_W-1:0]  acc_q;
  logic [ACC_W-1:0]  ftw_act;
  logic [OFS_W-1:0]  ofs_act;
  logic [TAB_AW-1:0] tab_addr;
  logic              neg_half;
  logic              neg_q;
  logic [AMP_W-1:0]  amp_q;
  logic [OUT_W-1:0]  pos_word;

  dds_phase_acc #(.ACC_W(ACC_W), .OFS_W(OFS_W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .ftw_stage(ftw_stage),
    .ofs_stage(ofs_stage),
    .upd      (upd),
    .pwr_dn   (pwr_dn),
    .acc_q    (acc_q),
    .ftw_act  (ftw_act),
    .ofs_act  (ofs_act)
  );

  dds_phase_map #(.OFS_W(OFS_W), .TAB_AW(TAB_AW)) u_map (
    .clk     (clk),
    .rst     (rst),
    .acc_top (acc_q[ACC_W-1 -: PH_W]),
    .ofs_act (ofs_act),
    .tab_addr(tab_addr),
    .neg_half(neg_half)
  );

  dds_sine_rom #(.AW(TAB_AW), .DW(AMP_W)) u_rom (
    .clk   (clk),
    .rst   (rst),
    .addr  (tab_addr),
    .data_q(amp_q)
  );

  // Sign follows the ROM by one register
  always_ff @(posedge clk) begin
    if (rst) begin
      neg_q <= 1'b0;
    end else begin
      neg_q <= neg_half;
    end
  end

  // Offset binary: positive half is MID + amp, negative half its complement
  assign pos_word = {1'b1, amp_q};

  always_ff @(posedge clk) begin
    if (rst || pwr_dn) begin
      sample <= MID;
    end else begin
      sample <= neg_q ? ~pos_word : pos_word;
    end
  end

  assign square = acc_q[ACC_W-1];

endmodule

// File: rtl/dds_nco_chk.sv
module dds_nco_chk #(
  parameter int ACC_W = 32,
  parameter int OFS_W = 5,
  parameter int OUT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic [ACC_W-1:0] ftw_stage,
  input logic [OFS_W-1:0] ofs_stage,
  input logic             upd,
  input logic             pwr_dn,
  input logic [OUT_W-1:0] sample,
  input logic [ACC_W-1:0] acc,
  input logic [ACC_W-1:0] ftw_act,
  input logic [OFS_W-1:0] ofs_act
);

  localparam logic [OUT_W-1:0] MID = OUT_W'(1) << (OUT_W - 1);

  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (acc == '0 && ftw_act == '0 && ofs_act == '0 && sample == MID)); // R1

  AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
    !pwr_dn |=> acc == $past(acc) + $past(ftw_act)); // R2

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !upd |=> (ftw_act == $past(ftw_act) && ofs_act == $past(ofs_act))); // R3

  AST_ACT_LOAD: assert property (@(posedge clk) disable iff (rst)
    upd |=> (ftw_act == $past(ftw_stage) && ofs_act == $past(ofs_stage))); // R3

  AST_PD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    pwr_dn |=> acc == $past(acc)); // R7

  AST_PD_MIDSCALE: assert property (@(posedge clk) disable iff (rst)
    pwr_dn |=> sample == MID); // R7

endmodule

bind dds_nco dds_nco_chk #(.ACC_W(ACC_W), .OFS_W(OFS_W), .OUT_W(OUT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ftw_stage(ftw_stage),
  .ofs_stage(ofs_stage),
  .upd      (upd),
  .pwr_dn   (pwr_dn),
  .sample   (sample),
  .acc      (acc_q),
  .ftw_act  (ftw_act),
  .ofs_act  (ofs_act)
);

// File: tb/dds_nco_bench.sv
module dds_nco_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ftw_stage = '0;
  logic [4:0]  ofs_stage = '0;
  logic        upd = 1'b0;
  logic        pwr_dn = 1'b0;
  logic [9:0]  sample;
  logic        square;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  dds_nco u_dds_nco (
    .clk      (clk),
    .rst      (rst),
    .ftw_stage(ftw_stage),
    .ofs_stage(ofs_stage),
    .upd      (upd),
    .pwr_dn   (pwr_dn),
    .sample   (sample),
    .square   (square)
  );

  // Reference model from the requirements
  function automatic int amp_of(input int m);
    return $rtoi(511.0 * $sin(6.283185307179586 * (real'(m) + 0.5) / 4096.0) + 0.5);
  endfunction

  function automatic int wave_of(input int ph);
    int q = (ph >> 10) & 3;
    int k = ph & 1023;
    int m = (q == 1 || q == 3) ? 1023 - k : k;
    return (q >= 2) ? 511 - amp_of(m) : 512 + amp_of(m);
  endfunction

  logic [31:0] acc_m, ftw_m;
  logic [4:0]  ofs_m;
  int          ph_d1, ph_d2, ph_d3;
  logic        pd_m;

  always @(posedge clk) begin
    if (rst) begin
      acc_m <= '0; ftw_m <= '0; ofs_m <= '0;
      ph_d1 <= 0; ph_d2 <= 0; ph_d3 <= 0; pd_m <= 1'b0;
    end else begin
      if (!pwr_dn) acc_m <= acc_m + ftw_m;
      if (upd) begin
        ftw_m <= ftw_stage;
        ofs_m <= ofs_stage;
      end
      ph_d1 <= (int'(acc_m[31:20]) + int'(ofs_m) * 128) % 4096;
      ph_d2 <= ph_d1;
      ph_d3 <= ph_d2;
      pd_m  <= pwr_dn;
    end
  end

  function automatic int expected_sample();
    return pd_m ? 512 : wave_of(ph_d3);
  endfunction

  task automatic chk(input int got, input int exp, input string req);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [31:0] f, input logic [4:0] o);
    ftw_stage = f;
    ofs_stage = o;
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    upd = 1'b0;
    pwr_dn = 1'b0;
    cycles(3);
    rst = 1'b0;
  endtask

  // Compares every sample with the model for n cycles
  task automatic run_cmp(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(int'(sample), expected_sample(), req);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    cycles(3);
    chk(int'(sample), 512, "R1 sample");
    chk(int'(square), 0, "R1 square");
    rst = 1'b0;
    cycles(5);
    chk(int'(sample), 512, "R1 zero tuning after reset");
  endtask

  task automatic t_offsets();
    do_reset();
    load(32'd0, 5'd8);
    cycles(4);
    chk(int'(sample), 1023, "R4 R5 quarter offset");
    load(32'd0, 5'd16);
    cycles(4);
    chk(int'(sample), 511, "R4 R5 half offset");
    load(32'd0, 5'd24);
    cycles(4);
    chk(int'(sample), 0, "R4 R5 three-quarter offset");
    load(32'd0, 5'd5);
    cycles(4);
    chk(int'(sample), wave_of(640), "R4 R5 offset 5");
  endtask

  task automatic t_staging();
    do_reset();
    ofs_stage = 5'd16;
    ftw_stage = 32'h1234_5678;
    cycles(6);
    chk(int'(sample), 512, "R3 staged values ignored");
    chk(int'(square), 0, "R3 staged tuning ignored");
    ftw_stage = 32'd0;
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    chk(int'(sample), 512, "R6 edge e");
    @(negedge clk);
    chk(int'(sample), 512, "R6 edge e+1");
    @(negedge clk);
    chk(int'(sample), 512, "R6 edge e+2");
    @(negedge clk);
    chk(int'(sample), 511, "R6 edge e+3");
  endtask

  task automatic t_sweep();
    do_reset();
    load(32'h0123_4567, 5'd0);
    run_cmp(300, "R5 R6 slow sweep");
    load(32'h4000_0000, 5'd3);
    run_cmp(40, "R5 R6 quarter step");
    load(32'hFFFF_FFFF, 5'd31);
    run_cmp(40, "R2 wrap negative step");
    load(32'h0FFF_F001, 5'd12);
    run_cmp(300, "R2 R5 fast sweep");
  endtask

  task automatic t_square();
    logic prev;
    int toggles;
    do_reset();
    load(32'h1000_0000, 5'd0);
    prev = square;
    toggles = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (square != prev) toggles++;
      prev = square;
    end
    chk(toggles, 8, "R2 square toggles every 8 cycles");
  endtask

  task automatic t_pdown();
    logic sq_hold;
    do_reset();
    load(32'h0800_0000, 5'd2);
    run_cmp(13, "R7 before power-down");
    pwr_dn = 1'b1;
    @(negedge clk);
    sq_hold = square;
    chk(int'(sample), 512, "R7 mid-scale first cycle");
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(int'(sample), 512, "R7 mid-scale held");
      chk(int'(square), int'(sq_hold), "R7 phase frozen");
    end
    pwr_dn = 1'b0;
    run_cmp(60, "R7 resume from held phase");
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_offsets();
    t_staging();
    t_sweep();
    t_square();
    t_pdown();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule